// File: doc/BRIEF.md
# Shared-Pin Parallel GPIO Port

A digital I/O port of `NUM_PINS` pins in which every pin is shared between the port's own registers and a peripheral. A small register bus reaches three registers: a direction register, an output latch and a pin-level view. Each pin has its own pair of output multiplexers. They hand the pad's output data and output enable to the peripheral whenever that peripheral is enabled and is actively driving. Otherwise the port's direction bit and latch bit control the pad.

A mask parameter marks pins that do not exist on a given build. Those bits read as zero in every register, and their pad is never driven. Pad levels cross into the clock domain through a two-stage synchronizer before they appear on port reads. The peripheral's input path is gated, so that the port's own driven output cannot loop back into the peripheral.

Top module: `gpio_shared_port`

## Requirements
- R1: After reset (`rst_ni` low), every implemented direction bit is 1, every pin is an input, the latch is zero and `pad_oe_o` is all zero.
- R2: Register address 0 holds the direction. A bit of 1 makes the pin an input with `pad_oe_o` low. A bit of 0 makes it an output that drives the latch bit on `pad_out_o`, unless the peripheral owns the pin.
- R3: A write at address 2 updates the latch on the next clock edge, and a read at address 2 returns the latch.
- R4: A write at address 1 updates the latch, not the pads. A read at address 1 returns the pad levels after a two-flop synchronizer, so a pad change is visible two clock edges later.
- R5: When `per_en_i` and `per_oe_i` are both 1 for a pin, `pad_oe_o` is 1 and `pad_out_o` equals `per_out_i`, whatever the direction and latch hold.
- R6: When `per_en_i` is 1 but `per_oe_i` is 0, the direction and latch bits control the pin exactly as in R2.
- R7: While the peripheral owns a pin, address 1 reads still return that pin's level.
- R8: For bits cleared in `IMPL_MASK`, the direction, latch and port reads return 0, and `pad_oe_o` and `pad_out_o` stay 0.
- R9: `per_in_o` is 0 for any pin whose `per_en_i` is 0. It is also 0 for any pin the port itself is driving (direction 0, peripheral not driving). In all other cases it carries the pad level.
- R10: Address 3 reads as zero. A write to address 3 changes neither the direction nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 direction, 1 pins, 2 latch |
| wdata_i | input | NUM_PINS | Write data |
| rdata_o | output | NUM_PINS | Read data of the selected register |
| pad_in_i | input | NUM_PINS | Pad input levels |
| pad_out_o | output | NUM_PINS | Pad output data |
| pad_oe_o | output | NUM_PINS | Pad output enable |
| per_en_i | input | NUM_PINS | Peripheral module enable, per pin |
| per_oe_i | input | NUM_PINS | Peripheral output enable, per pin |
| per_out_i | input | NUM_PINS | Peripheral output data, per pin |
| per_in_o | output | NUM_PINS | Gated pad level toward the peripheral |

## Verification
The bench builds the port with `NUM_PINS = 4` and `IMPL_MASK = 4'b1011`. With these values every vector covers one missing pin next to three real ones, and a single peripheral pattern can mix owned pins, port-driven pins and input pins. A four-bit width also keeps every expected register and pad value easy to work out by hand. This makes it possible to see the latch masking of writes at address 1, the synchronizer's two-edge latency, and the loop-through gate side by side.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_DIR  = 2'd0,
    REG_PIN  = 2'd1,
    REG_LAT  = 2'd2,
    REG_NONE = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int                NUM_PINS  = 8,
  parameter logic [NUM_PINS-1:0] IMPL_MASK = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0] pin_sync_i,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] lat_o,
  output logic [NUM_PINS-1:0] rdata_o
);
  logic [NUM_PINS-1:0] dir_q, lat_q;
  gpio_reg_e           sel;

  assign sel = gpio_reg_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= IMPL_MASK;
      lat_q <= '0;
    end else if (wr_en_i) begin
      unique case (sel)
        REG_DIR:          dir_q <= wdata_i & IMPL_MASK;
        REG_PIN, REG_LAT: lat_q <= wdata_i & IMPL_MASK; // pin writes land in latch
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      REG_DIR: rdata_o = dir_q;
      REG_PIN: rdata_o = pin_sync_i & IMPL_MASK;
      REG_LAT: rdata_o = lat_q;
      default: rdata_o = '0;
    endcase
  end

  assign dir_o = dir_q;
  assign lat_o = lat_q;

  // R3
  lat_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2) |=> (lat_q == ($past(wdata_i) & IMPL_MASK)));

  // R10
  null_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd3) |=> ($stable(dir_q) && $stable(lat_q)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter bit IMPL = 1'b1
) (
  input  logic dir_i,
  input  logic lat_i,
  input  logic pad_in_i,
  input  logic per_en_i,
  input  logic per_oe_i,
  input  logic per_out_i,
  output logic pad_out_o,
  output logic pad_oe_o,
  output logic per_in_o
);
  logic per_own, port_drive;

  assign per_own    = IMPL & per_en_i & per_oe_i;
  assign port_drive = IMPL & ~per_own & ~dir_i;

  assign pad_oe_o  = per_own | port_drive;
  assign pad_out_o = IMPL & (per_own ? per_out_i : lat_i);
  // block loop-through of the port's own drive into the peripheral
  assign per_in_o  = IMPL & per_en_i & ~port_drive & pad_in_i;
endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port
  import gpio_pkg::*;
#(
  parameter int                  NUM_PINS  = 8,
  parameter logic [NUM_PINS-1:0] IMPL_MASK = '1,
  parameter int                  SYNC_FF   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  input  logic [NUM_PINS-1:0] per_en_i,
  input  logic [NUM_PINS-1:0] per_oe_i,
  input  logic [NUM_PINS-1:0] per_out_i,
  output logic [NUM_PINS-1:0] per_in_o
);
  logic [NUM_PINS-1:0] pin_sync, dir, lat;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_FF)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pin_sync)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS), .IMPL_MASK(IMPL_MASK)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pin_sync_i(pin_sync),
    .dir_o     (dir),
    .lat_o     (lat),
    .rdata_o   (rdata_o)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_mux #(.IMPL(IMPL_MASK[p])) i_mux (
      .dir_i    (dir[p]),
      .lat_i    (lat[p]),
      .pad_in_i (pad_in_i[p]),
      .per_en_i (per_en_i[p]),
      .per_oe_i (per_oe_i[p]),
      .per_out_i(per_out_i[p]),
      .pad_out_o(pad_out_o[p]),
      .pad_oe_o (pad_oe_o[p]),
      .per_in_o (per_in_o[p])
    );
  end

  // R5
  per_own_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((per_oe_o_mask_ok(per_en_i & per_oe_i & IMPL_MASK, pad_oe_o, pad_out_o, per_out_i))));

  // R8
  unimpl_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o | pad_out_o | rdata_o | dir | lat) & ~IMPL_MASK) == '0);

  // R9
  per_in_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_in_o & ~per_en_i) == '0);

  // R2
  input_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & dir & ~(per_en_i & per_oe_i)) == '0);

  function automatic logic per_oe_o_mask_ok(input logic [NUM_PINS-1:0] own,
                                            input logic [NUM_PINS-1:0] oe,
                                            input logic [NUM_PINS-1:0] dout,
                                            input logic [NUM_PINS-1:0] pout);
    return ((own & ~oe) == '0) && ((own & (dout ^ pout)) == '0);
  endfunction
endmodule

// File: tb/test_gpio_shared_port.sv
module test_gpio_shared_port;
  localparam int              N    = 4;
  localparam logic [N-1:0]    IMPL = 4'b1011;

  typedef struct packed {
    logic [3:0]   req;
    logic         wr;
    logic [1:0]   waddr;
    logic [N-1:0] wdata;
    logic [1:0]   raddr;
    logic [N-1:0] pad;
    logic [N-1:0] pen;
    logic [N-1:0] poe;
    logic [N-1:0] pout;
    logic [N-1:0] e_rd;
    logic [N-1:0] e_out;
    logic [N-1:0] e_oe;
    logic [N-1:0] e_pin;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R3 R8: latch write masked by implemented bits
    '{4'd3,  1'b1, 2'd2, 4'b1111, 2'd2, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b1011, 4'b1011, 4'b0000, 4'b0000},
    // R2: all outputs
    '{4'd2,  1'b1, 2'd0, 4'b0000, 2'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b1011, 4'b1011, 4'b0000},
    // R4: pin-address write lands in latch
    '{4'd4,  1'b1, 2'd1, 4'b0101, 2'd2, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0001, 4'b1011, 4'b0000},
    // R4 R8: pin read, missing bit zero
    '{4'd4,  1'b0, 2'd0, 4'b0000, 2'd1, 4'b1110, 4'b0000, 4'b0000, 4'b0000, 4'b1010, 4'b0001, 4'b1011, 4'b0000},
    // R5 R7 R9: peripheral owns bits 1:0
    '{4'd5,  1'b0, 2'd0, 4'b0000, 2'd1, 4'b0110, 4'b1111, 4'b0011, 4'b0010, 4'b0010, 4'b0010, 4'b1011, 4'b0010},
    // R6 R9: peripheral enabled, not driving, pins inputs
    '{4'd6,  1'b1, 2'd0, 4'b1111, 2'd0, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b1011, 4'b0001, 4'b0000, 4'b1011},
    // R9: peripheral disabled gets zero
    '{4'd9,  1'b0, 2'd0, 4'b0000, 2'd1, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b1011, 4'b0001, 4'b0000, 4'b0000},
    // R5: peripheral overrides input direction and latch on bit 0
    '{4'd5,  1'b0, 2'd0, 4'b0000, 2'd2, 4'b0000, 4'b0001, 4'b0001, 4'b0000, 4'b0001, 4'b0000, 4'b0001, 4'b0000},
    // R10: address 3 reads zero
    '{4'd10, 1'b1, 2'd3, 4'b1111, 2'd3, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 4'b0000},
    // R10: latch unchanged by address 3 write
    '{4'd10, 1'b0, 2'd0, 4'b0000, 2'd2, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0001, 4'b0000, 4'b0000}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [N-1:0] wdata = '0, rdata, pad_in = '0, pad_out, pad_oe;
  logic [N-1:0] per_en = '0, per_oe = '0, per_out = '0, per_in;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_shared_port #(.NUM_PINS(N), .IMPL_MASK(IMPL)) i_gpio_shared_port (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .per_en_i(per_en), .per_oe_i(per_oe), .per_out_i(per_out), .per_in_o(per_in)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    addr = 2'd0; #1 check("R1 dir", rdata, IMPL);
    addr = 2'd2; #1 check("R1 lat", rdata, '0);
    check("R1 oe", pad_oe, '0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_en = VECS[v].wr; addr = VECS[v].waddr; wdata = VECS[v].wdata;
      pad_in = VECS[v].pad; per_en = VECS[v].pen; per_oe = VECS[v].poe; per_out = VECS[v].pout;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; addr = VECS[v].raddr;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vec%0d rdata", VECS[v].req, v), rdata, VECS[v].e_rd);
      check($sformatf("R%0d vec%0d pad_out", VECS[v].req, v), pad_out, VECS[v].e_out);
      check($sformatf("R%0d vec%0d pad_oe", VECS[v].req, v), pad_oe, VECS[v].e_oe);
      check($sformatf("R%0d vec%0d per_in", VECS[v].req, v), per_in, VECS[v].e_pin);
    end

    // R4: synchronizer latency of two edges
    @(negedge clk);
    addr = 2'd1; pad_in = 4'b1111;
    @(negedge clk);
    check("R4 after one edge", rdata, 4'b0000);
    @(negedge clk);
    check("R4 after two edges", rdata, 4'b1011);

    // R9: port-driven pin hides its level from an enabled peripheral
    wr_en = 1'b1; addr = 2'd0; wdata = 4'b0000;
    @(negedge clk);
    wr_en = 1'b0; per_en = 4'b1111; per_oe = 4'b0000;
    #1 check("R9 port drives", per_in, 4'b0000);
    check("R2 output enable", pad_oe, 4'b1011);

    // R1: reset mid-run restores defaults
    rst_n = 1'b0;
    #1 addr = 2'd0; #1 check("R1 dir after reset", rdata, IMPL);
    addr = 2'd2; #1 check("R1 lat after reset", rdata, '0);
    per_en = '0;
    #1 check("R1 oe after reset", pad_oe, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule